// File: doc/BRIEF.md
# Converter Serial Command Decoder

This block is the device side of a four-wire serial link to a data converter. It models the converter's command interpreter, and it can stand in for the real part in a system model or serve as a bus-functional target. While the select line is low, it samples the data-in line on each rising serial clock edge and groups the bits into bytes. Each byte is decoded as an opcode or as the argument of an opcode. Register read and write bursts run against a small internal register bank. A conversion result is delivered on an input port with a one-cycle valid strobe. The block tracks the result with an active-low data-ready output and returns it on the data-out line.

Commands that would act on the analog core (the calibrations, sync, standby, wakeup and the software reset) produce one-cycle strobes for the logic around the block. The software reset also restores the register bank. A continuous mode returns each new result without a read opcode. A bit of register 0 reverses the bit order of the returned result. The serial lines are sampled with the system clock, so the serial clock must be slow compared with it: at least three system cycles in each phase.

Top module: `conv_cmd_slave`

## Requirements
- R1: During and right after reset, data_ready_n is 1, miso is 0 and every command strobe is 0.
- R2: Each of these one-byte opcodes gives exactly one single-cycle strobe: 0xF0 to 0xF4 pulse cal_stb with cal_kind equal to the low three opcode bits; 0xFC pulses sync_stb; 0xFD pulses standby_stb; 0xFE pulses soft_reset_stb; both 0x00 and 0xFF pulse wakeup_stb. Undefined opcodes (for example 0x02, 0x30, 0xAA) produce no strobe and change no register.
- R3: The sequence 0001_aaaa, 0000_nnnn returns nnnn+1 register bytes, MSB first, on miso. The first byte comes from address aaaa, each later byte from the next address, and the address wraps from 15 to 0. Bytes on mosi during the returned data are ignored.
- R4: The sequence 0101_aaaa, 0000_nnnn followed by nnnn+1 data bytes writes those bytes to consecutive addresses starting at aaaa, wrapping from 15 to 0.
- R5: Opcode 0x01 shifts out the 24-bit result held at that moment, starting on the next serial clock. If bit 3 of register 0 is 0, bit 23 comes first. If it is 1, bit 0 comes first.
- R6: A result_valid pulse drives data_ready_n high in the next cycle and low in the cycle after that. Shifting out the 24th bit of a result drives data_ready_n high.
- R7: If select rises before all 24 result bits are shifted, data_ready_n stays low until the next result arrives.
- R8: Raising select discards any partial byte or unfinished command. The first full byte of the next frame is decoded as an opcode, and a write burst cut short changes no register for its unfinished byte.
- R9: After 0x03, each new unread result is shifted out, with no opcode, at the next byte boundary while select is low. Bytes on mosi are still decoded. After 0x0F no result is shifted out without an opcode.
- R10: Opcode 0xFE restores all registers to their power-up values (register 0 = 0x31, register k = k for k = 1 to 15) and leaves continuous mode.
- R11: miso is 0 whenever select is high or no data is being shifted.
- R12: If a new result arrives in the same cycle as the 24th bit of a read, data_ready_n is high in the next cycle, goes low one cycle later, and the next read returns the new result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock from the host |
| mosi | input | 1 | Serial data from the host, sampled on sclk rising edge |
| miso | output | 1 | Serial data to the host, valid before each sclk rising edge |
| result_data | input | 24 | New conversion result |
| result_valid | input | 1 | One-cycle strobe marking result_data as new |
| data_ready_n | output | 1 | Active-low data-ready |
| cal_stb | output | 1 | Calibration command strobe |
| cal_kind | output | 3 | Calibration variant, valid with cal_stb |
| sync_stb | output | 1 | Sync command strobe |
| standby_stb | output | 1 | Standby command strobe |
| wakeup_stb | output | 1 | Wakeup command strobe |
| soft_reset_stb | output | 1 | Software reset command strobe |

## Verification
The end of a result read and the arrival of a new result both act on data_ready_n, and they can fall in the same system cycle. The bench forces this by raising result_valid on the same clock edge that sees the 24th serial clock rise. It then checks that data_ready_n is high for exactly one cycle and low in the next, and that a following read returns the new value rather than the old one. Random register bursts and random results with random bit order are run against a bench register model around these directed cases.

// File: rtl/cmd_decoder_pkg.sv
package cmd_decoder_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_GETCNT,
        ST_WRDATA,
        ST_RDREG,
        ST_RDRES
    } dec_state_e;

    localparam logic [7:0] OP_RDATA    = 8'h01;
    localparam logic [7:0] OP_CONT_ON  = 8'h03;
    localparam logic [7:0] OP_CONT_OFF = 8'h0F;
    localparam logic [7:0] OP_SYNC     = 8'hFC;
    localparam logic [7:0] OP_STANDBY  = 8'hFD;
    localparam logic [7:0] OP_RESET    = 8'hFE;
    localparam logic [7:0] OP_WAKE_LO  = 8'h00;
    localparam logic [7:0] OP_WAKE_HI  = 8'hFF;
    localparam logic [3:0] OPH_RREG    = 4'h1;
    localparam logic [3:0] OPH_WREG    = 4'h5;
    localparam logic [4:0] OPH_CAL     = 5'b11110;
    localparam logic [2:0] CAL_MAX     = 3'd4;

endpackage

// File: rtl/ccs_serial_front.sv
module ccs_serial_front #(
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              mosi,
    output logic              rise_o,
    output logic              byte_done_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              at_boundary_o
);

    localparam int CNT_W = $clog2(BYTE_W);

    typedef struct packed {
        logic              sclk_prev;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] sr;
    } fe_t;

    fe_t q, d;

    always_comb begin
        d = q;
        d.sclk_prev = sclk;
        rise_o      = sclk & ~q.sclk_prev & ~cs_n;
        byte_o      = {q.sr[BYTE_W-2:0], mosi};
        byte_done_o = rise_o && (q.cnt == CNT_W'(BYTE_W - 1));
        at_boundary_o = (q.cnt == '0);
        if (cs_n) begin
            d.cnt = '0;
            d.sr  = '0;
        end else if (rise_o) begin
            d.sr  = byte_o;
            d.cnt = byte_done_o ? '0 : q.cnt + CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

endmodule

// File: rtl/ccs_reg_bank.sv
module ccs_reg_bank #(
    parameter int                   NREG       = 16,
    parameter int                   REG_W      = 8,
    parameter int                   ADDR_W     = $clog2(NREG),
    parameter logic [NREG*REG_W-1:0] RESET_VALS = '0,
    parameter int                   ORDER_BIT  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              restore,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [REG_W-1:0]  wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [REG_W-1:0]  rdata,
    output logic              order_o
);

    logic [REG_W-1:0] mem_q [NREG];
    logic [REG_W-1:0] mem_d [NREG];

    for (genvar g = 0; g < NREG; g++) begin : g_ent
        always_comb begin
            if (restore)
                mem_d[g] = RESET_VALS[g*REG_W +: REG_W];
            else if (we && (waddr == ADDR_W'(g)))
                mem_d[g] = wdata;
            else
                mem_d[g] = mem_q[g];
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) mem_q[g] <= RESET_VALS[g*REG_W +: REG_W];
            else        mem_q[g] <= mem_d[g];
        end
    end

    assign rdata   = mem_q[raddr];
    assign order_o = mem_q[0][ORDER_BIT];

endmodule

// File: rtl/ccs_out_shifter.sv
module ccs_out_shifter #(
    parameter int W     = 24,
    parameter int LEN_W = $clog2(W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             load,
    input  logic [W-1:0]     load_val,
    input  logic [LEN_W-1:0] load_len,
    input  logic             shift,
    output logic             bit_o,
    output logic             busy_o,
    output logic             last_o
);

    typedef struct packed {
        logic [W-1:0]     sr;
        logic [LEN_W-1:0] left;
    } sh_t;

    sh_t q, d;

    always_comb begin
        d = q;
        if (clear) begin
            d.sr   = '0;
            d.left = '0;
        end else if (load) begin
            d.sr   = load_val;
            d.left = load_len;
        end else if (shift && (q.left != '0)) begin
            d.sr   = {q.sr[W-2:0], 1'b0};
            d.left = q.left - LEN_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign bit_o  = q.sr[W-1];
    assign busy_o = (q.left != '0);
    assign last_o = (q.left == LEN_W'(1));

endmodule

// File: rtl/conv_cmd_slave.sv
module conv_cmd_slave
    import cmd_decoder_pkg::*;
#(
    parameter int                    RES_W      = 24,
    parameter int                    NREG       = 16,
    parameter int                    REG_W      = 8,
    parameter int                    ORDER_BIT  = 3,
    parameter logic [NREG*REG_W-1:0] RESET_VALS = 128'h0F0E_0D0C_0B0A_0908_0706_0504_0302_0131
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             sclk,
    input  logic             mosi,
    output logic             miso,
    input  logic [RES_W-1:0] result_data,
    input  logic             result_valid,
    output logic             data_ready_n,
    output logic             cal_stb,
    output logic [2:0]       cal_kind,
    output logic             sync_stb,
    output logic             standby_stb,
    output logic             wakeup_stb,
    output logic             soft_reset_stb
);

    localparam int ADDR_W = $clog2(NREG);
    localparam int LEN_W  = $clog2(RES_W + 1);
    localparam int CNT_W  = 4;

    typedef struct packed {
        dec_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [CNT_W-1:0]  cnt;
        logic              wr;
        logic              cont;
        logic              drdy_n;
        logic              pend;
        logic              fresh;
        logic              rd_res;
        logic [RES_W-1:0]  hold;
        logic              cal;
        logic [2:0]        cal_kind;
        logic              sync;
        logic              stby;
        logic              wake;
        logic              srst;
    } ctl_t;

    localparam ctl_t CTL_RST = '{
        st: ST_IDLE, addr: '0, cnt: '0, wr: 1'b0, cont: 1'b0, drdy_n: 1'b1,
        pend: 1'b0, fresh: 1'b0, rd_res: 1'b0, hold: '0, cal: 1'b0,
        cal_kind: '0, sync: 1'b0, stby: 1'b0, wake: 1'b0, srst: 1'b0
    };

    ctl_t q, d;

    logic              fe_rise, fe_done, fe_bound;
    logic [7:0]        fe_byte;
    logic              sh_load, sh_bit, sh_busy, sh_last;
    logic [RES_W-1:0]  sh_val;
    logic [LEN_W-1:0]  sh_len;
    logic              reg_we, reg_restore, order_lsb;
    logic [ADDR_W-1:0] reg_waddr, rd_addr;
    logic [REG_W-1:0]  reg_wdata, reg_rdata;
    logic [RES_W-1:0]  res_word;
    logic              cont_load_ok;

    function automatic logic [RES_W-1:0] flip_bits(input logic [RES_W-1:0] v);
        logic [RES_W-1:0] r;
        for (int i = 0; i < RES_W; i++) r[i] = v[RES_W-1-i];
        return r;
    endfunction

    ccs_serial_front #(.BYTE_W(8)) u_front (
        .clk          (clk),
        .rst_n        (rst_n),
        .cs_n         (cs_n),
        .sclk         (sclk),
        .mosi         (mosi),
        .rise_o       (fe_rise),
        .byte_done_o  (fe_done),
        .byte_o       (fe_byte),
        .at_boundary_o(fe_bound)
    );

    ccs_reg_bank #(
        .NREG      (NREG),
        .REG_W     (REG_W),
        .ADDR_W    (ADDR_W),
        .RESET_VALS(RESET_VALS),
        .ORDER_BIT (ORDER_BIT)
    ) u_regs (
        .clk    (clk),
        .rst_n  (rst_n),
        .restore(reg_restore),
        .we     (reg_we),
        .waddr  (reg_waddr),
        .wdata  (reg_wdata),
        .raddr  (rd_addr),
        .rdata  (reg_rdata),
        .order_o(order_lsb)
    );

    ccs_out_shifter #(.W(RES_W), .LEN_W(LEN_W)) u_shift (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (cs_n),
        .load    (sh_load),
        .load_val(sh_val),
        .load_len(sh_len),
        .shift   (fe_rise),
        .bit_o   (sh_bit),
        .busy_o  (sh_busy),
        .last_o  (sh_last)
    );

    assign res_word     = order_lsb ? flip_bits(q.hold) : q.hold;
    assign rd_addr      = (q.st == ST_RDREG) ? q.addr + ADDR_W'(1) : q.addr;
    assign cont_load_ok = q.cont && q.fresh && (q.st == ST_IDLE) && fe_bound && !sh_busy;

    always_comb begin
        d = q;
        d.cal  = 1'b0;
        d.sync = 1'b0;
        d.stby = 1'b0;
        d.wake = 1'b0;
        d.srst = 1'b0;
        sh_load     = 1'b0;
        sh_val      = '0;
        sh_len      = '0;
        reg_we      = 1'b0;
        reg_waddr   = q.addr;
        reg_wdata   = fe_byte;
        reg_restore = 1'b0;

        // result arrival: data-ready high this cycle, low the next
        if (result_valid) begin
            d.hold   = result_data;
            d.drdy_n = 1'b1;
            d.pend   = 1'b1;
            d.fresh  = 1'b0;
        end else if (q.pend) begin
            d.drdy_n = 1'b0;
            d.pend   = 1'b0;
            d.fresh  = 1'b1;
        end

        if (cs_n) begin
            d.st     = ST_IDLE;
            d.rd_res = 1'b0;
        end else if (fe_rise) begin
            // last result bit leaves: release data-ready unless newer data waits
            if (sh_last && q.rd_res) begin
                d.rd_res = 1'b0;
                if (!result_valid && !q.pend) d.drdy_n = 1'b1;
            end
            unique case (q.st)
                ST_IDLE: begin
                    if (fe_done) begin
                        if (fe_byte[7:4] == OPH_RREG || fe_byte[7:4] == OPH_WREG) begin
                            d.addr = fe_byte[ADDR_W-1:0];
                            d.wr   = (fe_byte[7:4] == OPH_WREG);
                            d.st   = ST_GETCNT;
                        end else if (fe_byte == OP_RDATA) begin
                            sh_load  = 1'b1;
                            sh_val   = res_word;
                            sh_len   = LEN_W'(RES_W);
                            d.fresh  = 1'b0;
                            d.rd_res = 1'b1;
                            d.st     = ST_RDRES;
                        end else if (fe_byte == OP_CONT_ON) begin
                            d.cont = 1'b1;
                        end else if (fe_byte == OP_CONT_OFF) begin
                            d.cont = 1'b0;
                        end else if (fe_byte[7:3] == OPH_CAL && fe_byte[2:0] <= CAL_MAX) begin
                            d.cal      = 1'b1;
                            d.cal_kind = fe_byte[2:0];
                        end else if (fe_byte == OP_SYNC) begin
                            d.sync = 1'b1;
                        end else if (fe_byte == OP_STANDBY) begin
                            d.stby = 1'b1;
                        end else if (fe_byte == OP_RESET) begin
                            d.srst      = 1'b1;
                            d.cont      = 1'b0;
                            reg_restore = 1'b1;
                        end else if (fe_byte == OP_WAKE_LO || fe_byte == OP_WAKE_HI) begin
                            d.wake = 1'b1;
                        end
                    end
                end
                ST_GETCNT: begin
                    if (fe_done) begin
                        d.cnt = fe_byte[CNT_W-1:0];
                        if (q.wr) begin
                            d.st = ST_WRDATA;
                        end else begin
                            sh_load = 1'b1;
                            sh_val  = {reg_rdata, {(RES_W-REG_W){1'b0}}};
                            sh_len  = LEN_W'(REG_W);
                            d.st    = ST_RDREG;
                        end
                    end
                end
                ST_WRDATA: begin
                    if (fe_done) begin
                        reg_we = 1'b1;
                        d.addr = q.addr + ADDR_W'(1);
                        if (q.cnt == '0) d.st = ST_IDLE;
                        else             d.cnt = q.cnt - CNT_W'(1);
                    end
                end
                ST_RDREG: begin
                    if (sh_last) begin
                        if (q.cnt == '0) begin
                            d.st = ST_IDLE;
                        end else begin
                            d.cnt   = q.cnt - CNT_W'(1);
                            d.addr  = q.addr + ADDR_W'(1);
                            sh_load = 1'b1;
                            sh_val  = {reg_rdata, {(RES_W-REG_W){1'b0}}};
                            sh_len  = LEN_W'(REG_W);
                        end
                    end
                end
                ST_RDRES: begin
                    if (sh_last) d.st = ST_IDLE;
                end
                default: d.st = ST_IDLE;
            endcase
        end else if (cont_load_ok) begin
            sh_load  = 1'b1;
            sh_val   = res_word;
            sh_len   = LEN_W'(RES_W);
            d.fresh  = 1'b0;
            d.rd_res = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= CTL_RST;
        else        q <= d;
    end

    assign miso           = ~cs_n & sh_busy & sh_bit;
    assign data_ready_n   = q.drdy_n;
    assign cal_stb        = q.cal;
    assign cal_kind       = q.cal_kind;
    assign sync_stb       = q.sync;
    assign standby_stb    = q.stby;
    assign wakeup_stb     = q.wake;
    assign soft_reset_stb = q.srst;

endmodule

// File: rtl/ccs_checker.sv
module ccs_checker (
    input logic clk,
    input logic rst_n,
    input logic cs_n,
    input logic miso,
    input logic result_valid,
    input logic data_ready_n,
    input logic cal_stb,
    input logic sync_stb,
    input logic standby_stb,
    input logic wakeup_stb,
    input logic soft_reset_stb
);

    logic any_stb;
    assign any_stb = cal_stb | sync_stb | standby_stb | wakeup_stb | soft_reset_stb;

    // R2: at most one command strobe at a time
    p_one_strobe_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cal_stb, sync_stb, standby_stb, wakeup_stb, soft_reset_stb}));

    // R2: strobes last a single cycle
    p_strobe_single_r2: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |=> !any_stb);

    // R8: a strobe only follows a cycle with select low
    p_strobe_in_frame_r8: assert property (@(posedge clk) disable iff (!rst_n)
        any_stb |-> $past(!cs_n));

    // R11: data-out quiet while deselected
    p_miso_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !miso);

    // R6: a new result raises data-ready next cycle
    p_drdy_high_r6: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> data_ready_n);

    // R6: and lowers it one cycle later
    p_drdy_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(result_valid) && !result_valid) |=> !data_ready_n);

endmodule

bind conv_cmd_slave ccs_checker u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cs_n          (cs_n),
    .miso          (miso),
    .result_valid  (result_valid),
    .data_ready_n  (data_ready_n),
    .cal_stb       (cal_stb),
    .sync_stb      (sync_stb),
    .standby_stb   (standby_stb),
    .wakeup_stb    (wakeup_stb),
    .soft_reset_stb(soft_reset_stb)
);

// File: tb/conv_cmd_slave_tb.sv
module conv_cmd_slave_tb;

    localparam logic [127:0] PWR_VALS = 128'h0F0E_0D0C_0B0A_0908_0706_0504_0302_0131;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        mosi = 1'b0;
    logic        miso;
    logic [23:0] result_data = '0;
    logic        result_valid = 1'b0;
    logic        data_ready_n;
    logic        cal_stb;
    logic [2:0]  cal_kind;
    logic        sync_stb, standby_stb, wakeup_stb, soft_reset_stb;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    int n_cal = 0, n_sync = 0, n_stby = 0, n_wake = 0, n_srst = 0;
    logic [2:0] last_kind = '0;

    logic [7:0] mdl [16];

    always #2 clk = ~clk;

    conv_cmd_slave u_dut (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .mosi(mosi), .miso(miso),
        .result_data(result_data), .result_valid(result_valid), .data_ready_n(data_ready_n),
        .cal_stb(cal_stb), .cal_kind(cal_kind), .sync_stb(sync_stb),
        .standby_stb(standby_stb), .wakeup_stb(wakeup_stb), .soft_reset_stb(soft_reset_stb)
    );

    always @(negedge clk) begin
        if (cal_stb)        begin n_cal++; last_kind = cal_kind; end
        if (sync_stb)       n_sync++;
        if (standby_stb)    n_stby++;
        if (wakeup_stb)     n_wake++;
        if (soft_reset_stb) n_srst++;
    end

    function automatic logic [23:0] rev24(input logic [23:0] v);
        logic [23:0] r;
        for (int i = 0; i < 24; i++) r[i] = v[23-i];
        return r;
    endfunction

    function automatic int strobe_total();
        return n_cal + n_sync + n_stby + n_wake + n_srst;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic frame_begin();
        cs_n = 1'b0;
        tick(2);
    endtask

    task automatic frame_end();
        tick(2);
        cs_n = 1'b1;
        tick(3);
    endtask

    task automatic xbit(input logic b, output logic r);
        mosi = b;
        tick(4);
        r = miso;
        sclk = 1'b1;
        tick(4);
        sclk = 1'b0;
    endtask

    task automatic xbyte(input logic [7:0] b, output logic [7:0] r);
        for (int i = 7; i >= 0; i--) begin
            logic t;
            xbit(b[i], t);
            r[i] = t;
        end
    endtask

    task automatic send_cmd(input logic [7:0] b);
        logic [7:0] junk;
        frame_begin();
        xbyte(b, junk);
        frame_end();
    endtask

    task automatic model_restore();
        for (int i = 0; i < 16; i++) mdl[i] = PWR_VALS[i*8 +: 8];
    endtask

    task automatic push_result(input logic [23:0] v, input bit check_pulse);
        result_data  = v;
        result_valid = 1'b1;
        tick(1);
        result_valid = 1'b0;
        if (check_pulse) chk("R6 drdy high after result", 32'(data_ready_n), 32'd1);
        tick(1);
        if (check_pulse) chk("R6 drdy low one cycle later", 32'(data_ready_n), 32'd0);
    endtask

    task automatic wreg_burst(input logic [3:0] a, input int n, input bit rnd, input logic [7:0] fixed);
        logic [7:0] junk;
        frame_begin();
        xbyte({4'h5, a}, junk);
        xbyte(8'(n - 1), junk);
        for (int i = 0; i < n; i++) begin
            logic [7:0] v;
            v = rnd ? 8'($urandom) : fixed;
            xbyte(v, junk);
            mdl[4'(a + 4'(i))] = v;
        end
        frame_end();
    endtask

    task automatic rreg_check(input logic [3:0] a, input int n, input string req);
        logic [7:0] r;
        frame_begin();
        xbyte({4'h1, a}, r);
        xbyte(8'(n - 1), r);
        for (int i = 0; i < n; i++) begin
            xbyte(8'h00, r);
            chk(req, 32'(r), 32'(mdl[4'(a + 4'(i))]));
        end
        frame_end();
    endtask

    task automatic read_result(output logic [23:0] v);
        logic [7:0] b0, b1, b2;
        frame_begin();
        xbyte(8'h01, b0);
        xbyte(8'h00, b0);
        xbyte(8'h00, b1);
        xbyte(8'h00, b2);
        frame_end();
        v = {b0, b1, b2};
    endtask

    function automatic logic [23:0] expect_stream(input logic [23:0] v);
        return mdl[0][3] ? rev24(v) : v;
    endfunction

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
            $finish;
        end
    end

    initial begin
        logic [23:0] got, v1, v2;
        logic [7:0]  r;
        int          tot;
        void'($urandom(32'h5EED_1234));
        model_restore();

        // R1: reset state
        tick(4);
        chk("R1 drdy in reset", 32'(data_ready_n), 32'd1);
        chk("R1 miso in reset", 32'(miso), 32'd0);
        chk("R1 strobes in reset", 32'(strobe_total()), 32'd0);
        rst_n = 1'b1;
        tick(3);
        chk("R1 drdy after reset", 32'(data_ready_n), 32'd1);

        // R3: full bank read and wrapped read of power-up values
        rreg_check(4'd0, 16, "R3 power-up read");
        rreg_check(4'd14, 4, "R3 wrap read");

        // R4: directed wrapped write, then random bursts
        wreg_burst(4'd15, 3, 1'b1, 8'h00);
        rreg_check(4'd15, 3, "R4 wrap write");
        for (int it = 0; it < 12; it++) begin
            logic [3:0] a;
            int n;
            a = 4'($urandom);
            n = 1 + int'($urandom % 16);
            wreg_burst(a, n, 1'b1, 8'h00);
            rreg_check(4'($urandom), 1 + int'($urandom % 16), "R4 random burst");
        end

        // R2: single-byte opcodes
        for (int k = 0; k <= 4; k++) begin
            tot = n_cal;
            send_cmd(8'hF0 + 8'(k));
            chk("R2 cal strobe count", 32'(n_cal - tot), 32'd1);
            chk("R2 cal kind", 32'(last_kind), 32'(k));
        end
        tot = n_sync; send_cmd(8'hFC); chk("R2 sync strobe", 32'(n_sync - tot), 32'd1);
        tot = n_stby; send_cmd(8'hFD); chk("R2 standby strobe", 32'(n_stby - tot), 32'd1);
        tot = n_wake; send_cmd(8'h00); send_cmd(8'hFF);
        chk("R2 wakeup both codes", 32'(n_wake - tot), 32'd2);
        tot = strobe_total();
        send_cmd(8'hAA); send_cmd(8'h02); send_cmd(8'h30);
        chk("R2 undefined opcodes silent", 32'(strobe_total() - tot), 32'd0);
        rreg_check(4'd0, 16, "R2 undefined opcodes leave registers");

        // R5/R6: random results with random bit order
        for (int it = 0; it < 8; it++) begin
            logic [7:0] s0;
            s0 = 8'($urandom);
            wreg_burst(4'd0, 1, 1'b0, s0);
            v1 = 24'($urandom);
            push_result(v1, 1'b1);
            read_result(got);
            chk("R5 result stream", 32'(got), 32'(expect_stream(v1)));
            chk("R6 drdy high after full read", 32'(data_ready_n), 32'd1);
        end
        wreg_burst(4'd0, 1, 1'b0, 8'h08);
        v1 = 24'hC00003;
        push_result(v1, 1'b0);
        read_result(got);
        chk("R5 LSB-first corner", 32'(got), 32'h0C0003 ^ 32'h0C0003 ^ 32'(rev24(v1)));
        wreg_burst(4'd0, 1, 1'b0, 8'h00);

        // R7: partial read keeps data-ready low
        push_result(24'h123456, 1'b1);
        frame_begin();
        xbyte(8'h01, r);
        xbyte(8'h00, r);
        chk("R7 first byte of partial", 32'(r), 32'h12);
        frame_end();
        chk("R7 drdy stays low", 32'(data_ready_n), 32'd0);
        tick(10);
        chk("R7 drdy still low later", 32'(data_ready_n), 32'd0);
        push_result(24'h654321, 1'b1);
        read_result(got);
        chk("R7 next result readable", 32'(got), 32'h654321);

        // R8: aborted partial byte then opcode decoded fresh
        frame_begin();
        for (int i = 0; i < 4; i++) begin
            logic t;
            xbit(1'b1, t);
        end
        frame_end();
        tot = n_sync;
        send_cmd(8'hFC);
        chk("R8 opcode after abort", 32'(n_sync - tot), 32'd1);
        frame_begin();
        xbyte(8'h53, r);
        xbyte(8'h00, r);
        for (int i = 0; i < 5; i++) begin
            logic t;
            xbit(1'b1, t);
        end
        frame_end();
        rreg_check(4'd3, 1, "R8 aborted write no effect");

        // R12: new result on the last bit of a read
        v1 = 24'hA5C3E1;
        v2 = 24'h0F1E2D;
        push_result(v1, 1'b0);
        frame_begin();
        xbyte(8'h01, r);
        xbyte(8'h00, r); got[23:16] = r;
        xbyte(8'h00, r); got[15:8] = r;
        for (int i = 7; i >= 1; i--) begin
            logic t;
            xbit(1'b0, t);
            got[i] = t;
        end
        mosi = 1'b0;
        tick(4);
        got[0] = miso;
        sclk = 1'b1;
        result_data  = v2;
        result_valid = 1'b1;
        tick(1);
        result_valid = 1'b0;
        chk("R12 drdy high in collision", 32'(data_ready_n), 32'd1);
        tick(1);
        chk("R12 drdy low after collision", 32'(data_ready_n), 32'd0);
        tick(2);
        sclk = 1'b0;
        frame_end();
        chk("R12 old result intact", 32'(got), 32'(v1));
        read_result(got);
        chk("R12 new result read next", 32'(got), 32'(v2));

        // R9: continuous mode
        send_cmd(8'h03);
        v1 = 24'h3C5A96;
        push_result(v1, 1'b1);
        frame_begin();
        xbyte(8'hAA, r); got[23:16] = r;
        xbyte(8'hAA, r); got[15:8] = r;
        xbyte(8'hAA, r); got[7:0] = r;
        frame_end();
        chk("R9 continuous result", 32'(got), 32'(v1));
        chk("R9 drdy high after continuous read", 32'(data_ready_n), 32'd1);
        send_cmd(8'h0F);
        push_result(24'hFFFFFF, 1'b1);
        frame_begin();
        xbyte(8'hAA, r);
        frame_end();
        chk("R9 stop continuous", 32'(r), 32'h00);
        chk("R11 miso idle frame", 32'(r), 32'h00);

        // R10: software reset restores registers and ends continuous mode
        wreg_burst(4'd5, 4, 1'b1, 8'h00);
        send_cmd(8'h03);
        tot = n_srst;
        send_cmd(8'hFE);
        model_restore();
        chk("R10 reset strobe", 32'(n_srst - tot), 32'd1);
        push_result(24'hFFFFFF, 1'b1);
        frame_begin();
        xbyte(8'hAA, r);
        frame_end();
        chk("R10 continuous cleared", 32'(r), 32'h00);
        rreg_check(4'd0, 16, "R10 registers restored");

        // R11: quiet while deselected
        tick(3);
        chk("R11 miso with select high", 32'(miso), 32'd0);

        done = 1'b1;
        $display("  TB_RESULT checks=%0d failures=%0d", n_checks, n_fails);
        $finish;
    end

endmodule